// File: doc/BRIEF.md
# Windowed Event Count Controller

This block sequences a duty-cycled sensing node through a fixed loop of reporting, recovering and counting. It counts debounced events from a comparator-style detector over a window of programmable length. When the window closes, it latches the count into a report word and raises a report flag. The flag stays up until an external reader session signals that it is done. The block then blanks the detector for a fixed recovery interval, which lets the analog front end settle after radio activity, and starts a new window.

All time is measured in ticks of a single enable input. Seconds in the field become a few clock cycles in simulation. Right after reset, the block copies a configured code once onto the control output for the detector's threshold attenuator. It then offers an empty report (count zero) before the first window ever runs. The live count is cleared once a report has been taken. The count saturates rather than wrapping.

Top module: `evt_window_seq`

## Requirements
- R1: `thr_code` is 0 during reset. It takes the value of `thr_cfg` on the first clock edge after reset release, and later changes of `thr_cfg` have no effect on it until the next reset.
- R2: Debounce works as follows.
  - The detector is sampled only on cycles where `tick_en` is 1.
  - An event is recognised when `det_in` is 1 on DEB_N consecutive ticks.
  - A high run yields at most one event.
  - A tick with `det_in` at 0 re-arms detection.
  - A run of fewer than DEB_N high ticks yields no event.
- R3: Each event recognised while counting raises the live count by one. The count saturates at 2^CNT_W-1.
- R4: Window length and report latch:
  - A window lasts `win_len` ticks, and a value of 0 acts as 1.
  - On the clock edge of its last tick, the count, including an event on that same tick, is copied to `rpt_count`.
  - `rpt_valid` rises on that same edge.
- R5: On the first clock edge after reset release, `rpt_valid` becomes 1 with `rpt_count` equal to 0, before any window has run.
- R6: Ending a report and recovering:
  - `sess_done` high while `rpt_valid` is 1 drops `rpt_valid` on the next edge and clears the live count.
  - It then starts a recovery interval of RECOV_TICKS ticks.
  - The window starts on the edge of the last recovery tick.
- R7: Detector activity during the report wait or during recovery is never counted.
- R8: `sess_done` while recovering or counting has no effect; the interval in progress runs to its normal end.
- R9: `rpt_count` changes only at the end of a window; it holds its value through the report wait, the recovery interval and the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time base enable, one pulse per time unit |
| det_in | input | 1 | Synchronous detector comparator output |
| sess_done | input | 1 | Strobe: reader session finished |
| win_len | input | WIN_W | Counting window length in ticks |
| thr_cfg | input | THR_W | Stored threshold code, applied once after reset |
| thr_code | output | THR_W | Threshold control code to the detector attenuator |
| rpt_count | output | CNT_W | Latched event count of the last finished window |
| rpt_valid | output | 1 | Report waiting for a reader session |

## Verification
The assertions check several rules on every cycle:
- the threshold code never moves after boot;
- the report word moves only on a counting cycle;
- a taken report drops the flag and clears the live count;
- the count never wraps;
- the debouncer never fires on two ticks in a row;
- counting and recovery ignore a stray session strobe.

Other behaviours can only be shown by the bench's scenarios:
- the exact edge on which a window or recovery interval ends;
- that a glitch shorter than the debounce length or a high run spread over sparse ticks is not counted;
- that activity during blanking is dropped;
- that a zero window length behaves as one tick.

// File: rtl/evt_pkg.sv
package evt_pkg;
    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_RECOV = 2'd2,
        ST_COUNT = 2'd3
    } seq_state_e;
endpackage

// File: rtl/evt_debounce.sv
module evt_debounce #(
    parameter int DEB_N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic det,
    output logic pulse
);
    localparam int HW = $clog2(DEB_N + 1);
    localparam logic [HW-1:0] HI_MAX = HW'(DEB_N);
    localparam logic [HW-1:0] HI_ARM = HW'(DEB_N - 1);

    logic [HW-1:0] hi_d, hi_q;

    // run length of high ticks, saturating at DEB_N so a run fires once
    always_comb begin
        hi_d  = hi_q;
        pulse = 1'b0;
        if (tick) begin
            if (!det) begin
                hi_d = '0;
            end else begin
                if (hi_q == HI_ARM) pulse = 1'b1;
                if (hi_q != HI_MAX) hi_d = hi_q + HW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_q <= '0;
        else        hi_q <= hi_d;
    end

    // R2: one high run never yields events on back-to-back cycles
    p_one_per_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] Q_MAX = '1;

    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (clr)                      q_d = '0;
        else if (inc && q_q != Q_MAX) q_d = q_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q == Q_MAX && !clr) |=> q_q == Q_MAX);
    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && q_q != Q_MAX) |=> q_q == $past(q_q) + W'(1));
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] q_d, q_q;
    logic [W:0]   nxt;

    always_comb begin
        nxt  = {1'b0, q_q} + (W+1)'(1);
        done = tick && (nxt >= {1'b0, limit});
        q_d  = q_q;
        if (clr)       q_d = '0;
        else if (tick) q_d = nxt[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end
endmodule

// File: rtl/evt_window_seq.sv
module evt_window_seq
    import evt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int WIN_W       = 32,
    parameter int THR_W       = 4,
    parameter int DEB_N       = 3,
    parameter int RECOV_TICKS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             det_in,
    input  logic             sess_done,
    input  logic [WIN_W-1:0] win_len,
    input  logic [THR_W-1:0] thr_cfg,
    output logic [THR_W-1:0] thr_code,
    output logic [CNT_W-1:0] rpt_count,
    output logic             rpt_valid
);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [WIN_W-1:0] RECOV_LIM = WIN_W'(RECOV_TICKS);
    localparam logic [WIN_W-1:0] ONE_TICK  = WIN_W'(1);

    typedef struct packed {
        seq_state_e       st;
        logic [THR_W-1:0] thr;
        logic [CNT_W-1:0] rpt;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             evt_pulse;
    logic             cnt_clr, cnt_inc;
    logic [CNT_W-1:0] cnt_q, cnt_sat;
    logic             tmr_clr, tmr_done;
    logic [WIN_W-1:0] tmr_limit;

    evt_debounce #(.DEB_N(DEB_N)) i_deb (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .det(det_in), .pulse(evt_pulse)
    );

    evt_counter #(.W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .q(cnt_q)
    );

    ivl_timer #(.W(WIN_W)) i_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick_en),
        .limit(tmr_limit), .done(tmr_done)
    );

    always_comb begin
        r_d       = r_q;
        cnt_clr   = 1'b0;
        tmr_clr   = 1'b1;
        cnt_inc   = evt_pulse && (r_q.st == ST_COUNT);
        cnt_sat   = (cnt_inc && cnt_q != CNT_MAX) ? cnt_q + CNT_W'(1) : cnt_q;
        if (r_q.st == ST_RECOV)  tmr_limit = RECOV_LIM;
        else if (win_len == '0)  tmr_limit = ONE_TICK;
        else                     tmr_limit = win_len;
        unique case (r_q.st)
            ST_BOOT: begin
                r_d.thr = thr_cfg;
                r_d.st  = ST_WAIT;
            end
            ST_WAIT: begin
                if (sess_done) begin
                    r_d.st  = ST_RECOV;
                    cnt_clr = 1'b1;
                end
            end
            ST_RECOV: begin
                tmr_clr = 1'b0;
                if (tmr_done) begin
                    r_d.st  = ST_COUNT;
                    tmr_clr = 1'b1;
                    cnt_clr = 1'b1;
                end
            end
            ST_COUNT: begin
                tmr_clr = 1'b0;
                if (tmr_done) begin
                    r_d.st  = ST_WAIT;
                    r_d.rpt = cnt_sat;
                    tmr_clr = 1'b1;
                end
            end
            default: r_d.st = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_BOOT;
            r_q.thr <= '0;
            r_q.rpt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign thr_code  = r_q.thr;
    assign rpt_count = r_q.rpt;
    assign rpt_valid = (r_q.st == ST_WAIT);

    p_thr_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_BOOT) |=> $stable(thr_code));
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && sess_done) |=> (!rpt_valid && cnt_q == '0));
    p_count_runs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_COUNT && !tmr_done) |=> r_q.st == ST_COUNT);
    p_recov_runs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RECOV && !tmr_done) |=> r_q.st == ST_RECOV);
    p_rpt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_COUNT) |=> $stable(rpt_count));
endmodule

// File: tb/test_evt_window_seq.sv
module test_evt_window_seq;
    localparam int CW = 4, WW = 8, TW = 4, DN = 2, RT = 3;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tick_en = 1'b1, det_in = 1'b0, sess_done = 1'b0;
    logic [WW-1:0] win_len = 8'd5;
    logic [TW-1:0] thr_cfg = 4'hA;
    logic [TW-1:0] thr_code;
    logic [CW-1:0] rpt_count;
    logic          rpt_valid;

    int total = 0, bad = 0;

    evt_window_seq #(.CNT_W(CW), .WIN_W(WW), .THR_W(TW), .DEB_N(DN), .RECOV_TICKS(RT))
    i_evt_window_seq (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .det_in(det_in),
        .sess_done(sess_done), .win_len(win_len), .thr_cfg(thr_cfg),
        .thr_code(thr_code), .rpt_count(rpt_count), .rpt_valid(rpt_valid)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: phase 0 boot, 1 report wait, 2 blanking, 3 window
    int m_phase = 0, m_thr = 0, m_rpt = 0, m_live = 0, m_elapsed = 0, m_run = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_thr = 0; m_rpt = 0; m_live = 0; m_elapsed = 0; m_run = 0;
        end else begin
            bit hit;
            int span;
            hit = 0;
            if (tick_en) begin
                if (det_in) begin m_run++; hit = (m_run == DN); end
                else m_run = 0;
            end
            span = (win_len == 0) ? 1 : int'(win_len);
            case (m_phase)
                0: begin m_thr = int'(thr_cfg); m_phase = 1; end
                1: if (sess_done) begin m_live = 0; m_elapsed = 0; m_phase = 2; end
                2: if (tick_en) begin
                       m_elapsed++;
                       if (m_elapsed == RT) begin m_elapsed = 0; m_live = 0; m_phase = 3; end
                   end
                default: begin
                    if (hit && m_live < CMAX) m_live++;
                    if (tick_en) begin
                        m_elapsed++;
                        if (m_elapsed >= span) begin
                            m_rpt = m_live; m_elapsed = 0; m_phase = 1;
                        end
                    end
                end
            endcase
        end
        #2;
        chk("R1 model thr_code", thr_code, m_thr);
        chk("R3 model rpt_count", rpt_count, m_rpt);
        chk("R4 model rpt_valid", rpt_valid, (m_phase == 1) ? 1 : 0);
    end

    task automatic wait_report();
        int k = 0;
        while (!rpt_valid && k < 500) begin @(negedge clk); k++; end
        if (k >= 500) chk("R4 report never raised", 0, 1);
    endtask

    always begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL R6 watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 thr_code in reset", thr_code, 0);
        chk("R5 rpt_valid in reset", rpt_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 first report valid", rpt_valid, 1);
        chk("R5 first report empty", rpt_count, 0);
        chk("R1 thr_code loaded", thr_code, 4'hA);
        thr_cfg = 4'h5;
        det_in = 1'b1;                         // R7: high while waiting
        repeat (4) @(negedge clk);
        sess_done = 1'b1;                      // n0
        @(negedge clk); sess_done = 1'b0;      // n1
        chk("R6 valid drops after session", rpt_valid, 0);
        @(negedge clk); det_in = 1'b0;         // n2
        @(negedge clk);                        // n3 recovery tick 3
        @(negedge clk); det_in = 1'b1;         // n4 window tick 1
        @(negedge clk);                        // n5 event
        @(negedge clk); det_in = 1'b0; sess_done = 1'b1; // n6 R8 stray strobe
        @(negedge clk); det_in = 1'b1; sess_done = 1'b0; // n7 glitch
        @(negedge clk);                        // n8
        chk("R8 window not cut short", rpt_valid, 0);
        det_in = 1'b0;
        @(negedge clk);                        // n9
        chk("R4 report at window end", rpt_valid, 1);
        chk("R2 R7 one debounced event", rpt_count, 1);
        chk("R1 thr_code ignores later cfg", thr_code, 4'hA);

        // saturation
        win_len = 8'd60;
        sess_done = 1'b1;
        @(negedge clk); sess_done = 1'b0;
        for (int i = 0; i < 30; i++) begin
            det_in = 1'b1; @(negedge clk);
            @(negedge clk);
            det_in = 1'b0; @(negedge clk);
            if (i == 5) chk("R9 report held during window", rpt_count, 1);
        end
        wait_report();
        chk("R3 count saturates", rpt_count, CMAX);

        // zero window length acts as one tick
        win_len = 8'd0;
        sess_done = 1'b1;
        @(negedge clk); sess_done = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R9 report held in recovery", rpt_count, CMAX);
        @(negedge clk);
        chk("R4 zero window not yet done", rpt_valid, 0);
        @(negedge clk);
        chk("R4 zero window is one tick", rpt_valid, 1);
        chk("R6 count cleared after report", rpt_count, 0);

        // sparse ticks: each 2-cycle high run holds only one tick
        win_len = 8'd6;
        sess_done = 1'b1;
        @(negedge clk); sess_done = 1'b0;
        for (int i = 0; i < 60; i++) begin
            tick_en = i[0];
            det_in  = ((i % 10) < 2);
            @(negedge clk);
        end
        tick_en = 1'b1; det_in = 1'b0;
        wait_report();
        chk("R2 sub-length run across ticks ignored", rpt_count, 0);
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule